// File: doc/BRIEF.md
# Linked Instruction Breakpoint Comparator Unit

This block watches the instruction fetch stream of a processor and raises a breakpoint debug event when a programmed condition holds. It contains six breakpoint slots. Each slot has a value register and a control register, and both are loaded through a narrow register-write port. In every cycle that carries a valid fetch, each enabled slot compares its value against either the word address of the fetch or the current context ID. The unit then registers a per-slot hit vector and a single event line.

An address slot can fire on equality, or on inequality. Inequality lets a debugger step one instruction: it arms the slot with the current address, so the next different address breaks. An address slot can also be linked to a context slot. It then fires only when its address condition and the context comparison both hold in the same cycle. Only the two top slots can compare context IDs. A hit that rests on a context ID alone, or on address inequality, is dropped while the processor runs privileged and debug is in monitor mode. This keeps a monitor handler from trapping on itself.

Top module: `bkpt_unit`

## Requirements
- R1: A write with `wr_en` high stores `wr_data` into slot `wr_idx`. It goes to the control register when `wr_ctl` is 1 and to the value register when `wr_ctl` is 0. A write to an index of 6 or 7 changes no slot. A new setting governs compares from the next cycle.
- R2: The control word has these fields: bit 0 enable, bit 1 mismatch select, bit 2 context target, bit 3 link enable, bits 6:4 linked slot index. A slot whose enable is 0 never reports a hit.
- R3: Slots 0 to 3 store the context-target bit as 0 whatever is written, so they always behave as address slots. Slots 4 and 5 keep the bit as written.
- R4: An enabled address slot with mismatch 0 hits when `fetch_addr` equals bits 31:2 of its value register.
- R5: An enabled address slot with mismatch 1 hits when `fetch_addr` differs from bits 31:2 of its value register.
- R6: An enabled slot 4 or 5 with the context target set hits when `ctx_id` equals its full 32-bit value. The mismatch bit has no effect in this mode.
- R7: An address slot with link enable set hits only if its address condition holds and the linked slot holds the context target and its value equals `ctx_id`. The linked slot's own enable is not needed for the link.
- R8: While `priv_mode` and `monitor_mode` are both 1, context-only hits and address-mismatch hits are dropped. Address-equality hits, linked or not, still fire.
- R9: Hits are produced only for cycles in which `fetch_valid` is 1. They appear on `bp_hits` one clock after the fetch and last one cycle.
- R10: `bp_event` is 1 in exactly the cycles in which any bit of `bp_hits` is 1.
- R11: Synchronous reset clears every control and value register and both outputs, so nothing fires until software programs a slot.
- R12: A link whose index names slot 0 to 3, slot 6 or 7, or a slot not in context mode never satisfies the link condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_ctl | input | 1 | 1 selects the control register, 0 the value register |
| wr_idx | input | 3 | Slot index of the write |
| wr_data | input | 32 | Write data |
| fetch_valid | input | 1 | Fetch in this cycle is a real instruction fetch |
| fetch_addr | input | 30 | Word address of the fetch |
| ctx_id | input | 32 | Current context ID |
| priv_mode | input | 1 | Processor runs in a privileged mode |
| monitor_mode | input | 1 | Debug logic is in monitor mode |
| bp_hits | output | 6 | Registered per-slot hit vector |
| bp_event | output | 1 | Registered breakpoint debug event |

## Verification
The embedded properties check on every cycle that a disabled slot stays silent, that no hit follows a cycle without a fetch, that monitor-privileged cycles never yield context-only or mismatch hits, that the low slots never hold the context bit, that reset empties the enables, and that the event line tracks the hit vector. The compare results themselves cannot be seen by a property without copying the logic: the equality and inequality outcomes, the linked pairing with a context slot, invalid link targets, and the discarded writes to slots 6 and 7. Directed scenarios and a long random run, checked against a bench model, show those.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;

  // Control word of one slot; packed order gives bit 0 = enable .. bits 6:4 = link index
  typedef struct packed {
    logic [2:0] link_idx;
    logic       link_en;
    logic       ctx_sel;
    logic       mismatch;
    logic       enable;
  } bp_ctrl_t;

  localparam int CTRL_W   = $bits(bp_ctrl_t);
  localparam int LINK_SPAN = 8;

  // Build a control word from bus data; the context bit survives only on capable slots
  function automatic bp_ctrl_t decode_ctrl(input logic [CTRL_W-1:0] raw, input logic ctx_ok);
    bp_ctrl_t c;
    c = bp_ctrl_t'(raw);
    c.ctx_sel = c.ctx_sel & ctx_ok;
    return c;
  endfunction

endpackage

// File: rtl/bkpt_regs.sv
module bkpt_regs
  import bkpt_pkg::*;
#(
  parameter int NUM_PAIRS = 6,
  parameter int CTX_FIRST = 4,
  parameter int DATA_W    = 32,
  parameter int IDX_W     = 3
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              wr_en,
  input  logic                              wr_ctl,
  input  logic [IDX_W-1:0]                  wr_idx,
  input  logic [DATA_W-1:0]                 wr_data,
  output logic [NUM_PAIRS-1:0][DATA_W-1:0]  val_q,
  output bp_ctrl_t [NUM_PAIRS-1:0]          ctrl_q
);

  for (genvar i = 0; i < NUM_PAIRS; i++) begin : g_slot
    localparam logic CTX_OK = (i >= CTX_FIRST);
    logic hit_me;
    assign hit_me = wr_en && (wr_idx == IDX_W'(i));

    always_ff @(posedge clk) begin
      if (rst) begin
        val_q[i]  <= '0;
        ctrl_q[i] <= '0;
      end else if (hit_me) begin
        if (wr_ctl) ctrl_q[i] <= decode_ctrl(wr_data[CTRL_W-1:0], CTX_OK);
        else        val_q[i]  <= wr_data;
      end
    end

    if (i < CTX_FIRST) begin : g_addr_only
      AST_LOW_SLOT_NO_CTX: assert property (@(posedge clk) disable iff (rst)
        !ctrl_q[i].ctx_sel); // R3
    end

    AST_RESET_CLEARS_EN: assert property (@(posedge clk)
      rst |=> !ctrl_q[i].enable); // R11
  end

endmodule

// File: rtl/bkpt_pair_cmp.sv
module bkpt_pair_cmp #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 30
) (
  input  logic [DATA_W-1:0] val,
  input  logic              mismatch,
  input  logic [ADDR_W-1:0] fetch_addr,
  input  logic [DATA_W-1:0] ctx_id,
  output logic              addr_cond,
  output logic              ctx_eq
);

  localparam int LSB = DATA_W - ADDR_W;

  logic addr_eq;
  assign addr_eq   = (val[DATA_W-1:LSB] == fetch_addr);
  assign addr_cond = mismatch ? !addr_eq : addr_eq;
  assign ctx_eq    = (val == ctx_id);

endmodule

// File: rtl/bkpt_hit_qual.sv
module bkpt_hit_qual
  import bkpt_pkg::*;
#(
  parameter int NUM_PAIRS = 6,
  parameter int CTX_FIRST = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  bp_ctrl_t [NUM_PAIRS-1:0]  ctrl,
  input  logic [NUM_PAIRS-1:0]      addr_cond,
  input  logic [NUM_PAIRS-1:0]      ctx_eq,
  input  logic                      fetch_valid,
  input  logic                      priv_mode,
  input  logic                      monitor_mode,
  output logic [NUM_PAIRS-1:0]      bp_hits,
  output logic                      bp_event
);

  logic                  quiet;
  logic [NUM_PAIRS-1:0]  link_ok;
  logic [LINK_SPAN-1:0]  link_ext;
  logic [NUM_PAIRS-1:0]  hit_nxt;

  assign quiet = priv_mode && monitor_mode;

  for (genvar j = 0; j < NUM_PAIRS; j++) begin : g_link
    if (j >= CTX_FIRST) begin : g_cap
      assign link_ok[j] = ctrl[j].ctx_sel && ctx_eq[j];
    end else begin : g_nocap
      assign link_ok[j] = 1'b0;
    end
  end
  assign link_ext = LINK_SPAN'(link_ok);

  for (genvar i = 0; i < NUM_PAIRS; i++) begin : g_hit
    logic ctx_hit, addr_hit;
    assign ctx_hit  = ctx_eq[i] && !quiet;
    assign addr_hit = addr_cond[i]
                    && (!ctrl[i].link_en || link_ext[ctrl[i].link_idx])
                    && !(ctrl[i].mismatch && quiet);
    assign hit_nxt[i] = fetch_valid && ctrl[i].enable &&
                        (ctrl[i].ctx_sel ? ctx_hit : addr_hit);

    AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (rst)
      !ctrl[i].enable |=> !bp_hits[i]); // R2

    AST_MONITOR_DROPS: assert property (@(posedge clk) disable iff (rst)
      (quiet && (ctrl[i].ctx_sel || ctrl[i].mismatch)) |=> !bp_hits[i]); // R8
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bp_hits  <= '0;
      bp_event <= 1'b0;
    end else begin
      bp_hits  <= hit_nxt;
      bp_event <= |hit_nxt;
    end
  end

  AST_NO_FETCH_NO_HIT: assert property (@(posedge clk) disable iff (rst)
    !fetch_valid |=> (bp_hits == '0)); // R9

  AST_EVENT_TRACKS_HITS: assert property (@(posedge clk) disable iff (rst)
    bp_event == (bp_hits != '0)); // R10

endmodule

// File: rtl/bkpt_unit.sv
module bkpt_unit
  import bkpt_pkg::*;
#(
  parameter int NUM_PAIRS = 6,
  parameter int CTX_FIRST = 4,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 30,
  parameter int IDX_W     = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic                  wr_ctl,
  input  logic [IDX_W-1:0]      wr_idx,
  input  logic [DATA_W-1:0]     wr_data,
  input  logic                  fetch_valid,
  input  logic [ADDR_W-1:0]     fetch_addr,
  input  logic [DATA_W-1:0]     ctx_id,
  input  logic                  priv_mode,
  input  logic                  monitor_mode,
  output logic [NUM_PAIRS-1:0]  bp_hits,
  output logic                  bp_event
);

  logic [NUM_PAIRS-1:0][DATA_W-1:0] val_q;
  bp_ctrl_t [NUM_PAIRS-1:0]         ctrl_q;
  logic [NUM_PAIRS-1:0]             addr_cond;
  logic [NUM_PAIRS-1:0]             ctx_eq;

  bkpt_regs #(
    .NUM_PAIRS(NUM_PAIRS), .CTX_FIRST(CTX_FIRST), .DATA_W(DATA_W), .IDX_W(IDX_W)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_ctl(wr_ctl), .wr_idx(wr_idx),
    .wr_data(wr_data), .val_q(val_q), .ctrl_q(ctrl_q)
  );

  for (genvar i = 0; i < NUM_PAIRS; i++) begin : g_cmp
    bkpt_pair_cmp #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_cmp (
      .val(val_q[i]), .mismatch(ctrl_q[i].mismatch), .fetch_addr(fetch_addr),
      .ctx_id(ctx_id), .addr_cond(addr_cond[i]), .ctx_eq(ctx_eq[i])
    );
  end

  bkpt_hit_qual #(.NUM_PAIRS(NUM_PAIRS), .CTX_FIRST(CTX_FIRST)) u_qual (
    .clk(clk), .rst(rst), .ctrl(ctrl_q), .addr_cond(addr_cond), .ctx_eq(ctx_eq),
    .fetch_valid(fetch_valid), .priv_mode(priv_mode), .monitor_mode(monitor_mode),
    .bp_hits(bp_hits), .bp_event(bp_event)
  );

endmodule

// File: tb/sim_bkpt_unit.sv
module sim_bkpt_unit;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 0, wr_ctl = 0;
  logic [2:0]  wr_idx = '0;
  logic [31:0] wr_data = '0;
  logic        fetch_valid = 0;
  logic [29:0] fetch_addr = '0;
  logic [31:0] ctx_id = '0;
  logic        priv_mode = 0, monitor_mode = 0;
  logic [5:0]  bp_hits;
  logic        bp_event;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [6:0]  m_ctl [6];
  logic [31:0] m_val [6];

  always #10 clk = ~clk;

  bkpt_unit u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_ctl(wr_ctl), .wr_idx(wr_idx),
    .wr_data(wr_data), .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
    .ctx_id(ctx_id), .priv_mode(priv_mode), .monitor_mode(monitor_mode),
    .bp_hits(bp_hits), .bp_event(bp_event)
  );

  function automatic logic [5:0] model_hits(input logic fv, input logic [29:0] a,
                                            input logic [31:0] c, input logic q);
    logic [5:0] h = '0;
    for (int i = 0; i < 6; i++) begin
      logic cond;
      if (m_ctl[i][2]) cond = (c == m_val[i]) && !q;
      else begin
        cond = m_ctl[i][1] ? (a != m_val[i][31:2]) : (a == m_val[i][31:2]);
        if (m_ctl[i][3]) begin
          int l = int'(m_ctl[i][6:4]);
          cond = cond && (l >= 4) && (l < 6) && m_ctl[l][2] && (c == m_val[l]);
        end
        if (m_ctl[i][1] && q) cond = 0;
      end
      h[i] = fv && m_ctl[i][0] && cond;
    end
    return h;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Called at a falling edge: drives one cycle, checks outputs at the next falling edge
  task automatic step(input string tag, input logic we, input logic wc, input logic [2:0] wi,
                      input logic [31:0] wd, input logic fv, input logic [29:0] a,
                      input logic [31:0] c, input logic pm, input logic mm);
    logic [5:0] exp;
    wr_en = we; wr_ctl = wc; wr_idx = wi; wr_data = wd;
    fetch_valid = fv; fetch_addr = a; ctx_id = c; priv_mode = pm; monitor_mode = mm;
    exp = model_hits(fv, a, c, pm && mm);
    if (we && wi < 6) begin
      if (wc) begin
        m_ctl[wi] = wd[6:0];
        if (wi < 4) m_ctl[wi][2] = 1'b0;
      end else m_val[wi] = wd;
    end
    @(posedge clk); @(negedge clk);
    check({tag, " hits"}, 32'(bp_hits), 32'(exp));
    check({tag, " event"}, 32'(bp_event), 32'(|exp));
  endtask

  task automatic wr(input logic wc, input logic [2:0] wi, input logic [31:0] wd);
    step("R1 write", 1, wc, wi, wd, 0, '0, '0, 0, 0);
  endtask

  task automatic fetch(input string tag, input logic [29:0] a, input logic [31:0] c,
                       input logic pm, input logic mm);
    step(tag, 0, 0, '0, '0, 1, a, c, pm, mm);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < 6; i++) begin m_ctl[i] = '0; m_val[i] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    check("R11 reset hits", 32'(bp_hits), 0);
    check("R11 reset event", 32'(bp_event), 0);
    fetch("R11 unprogrammed", 30'h0, 32'h0, 0, 0);

    // R4 equality
    wr(0, 3'd0, 32'h40); wr(1, 3'd0, 32'h1);
    fetch("R4 equal", 30'h10, 0, 0, 0);
    check("R4 literal", 32'(bp_hits), 32'h01);
    fetch("R4 differ", 30'h11, 0, 0, 0);
    // R5 mismatch
    wr(0, 3'd1, 32'h40); wr(1, 3'd1, 32'h3);
    fetch("R5 same", 30'h10, 0, 0, 0);
    fetch("R5 other", 30'h11, 0, 0, 0);
    check("R5 literal", 32'(bp_hits), 32'h02);
    // R9 no fetch
    step("R9 idle", 0, 0, 0, 0, 0, 30'h11, 0, 0, 0);
    // R8 suppression
    fetch("R8 mismatch dropped", 30'h11, 0, 1, 1);
    check("R8 literal", 32'(bp_hits), 32'h00);
    fetch("R8 equal kept", 30'h10, 0, 1, 1);
    fetch("R8 priv only", 30'h11, 0, 1, 0);
    // R6 context only
    wr(0, 3'd4, 32'hABCD); wr(1, 3'd4, 32'h7);
    fetch("R6 ctx hit", 30'h3F, 32'hABCD, 0, 0);
    check("R6 literal", 32'(bp_hits), 32'h12);
    fetch("R8 ctx dropped", 30'h10, 32'hABCD, 1, 1);
    // R7 link
    wr(0, 3'd5, 32'h1234); wr(1, 3'd5, 32'h4);
    wr(0, 3'd2, 32'h80); wr(1, 3'd2, 32'h59);
    wr(1, 3'd1, 32'h0);
    fetch("R7 linked", 30'h20, 32'h1234, 0, 0);
    check("R7 literal", 32'(bp_hits), 32'h04);
    fetch("R7 ctx off", 30'h20, 32'h1235, 0, 0);
    fetch("R8 linked kept", 30'h20, 32'h1234, 1, 1);
    // R12 bad link targets
    wr(0, 3'd3, 32'h80); wr(1, 3'd3, 32'h19);
    fetch("R12 addr target", 30'h20, 32'h1234, 0, 0);
    wr(1, 3'd3, 32'h79);
    fetch("R12 index 7", 30'h20, 32'h1234, 0, 0);
    check("R12 literal", 32'(bp_hits), 32'h04);
    // R3 low slot ignores ctx bit
    wr(1, 3'd3, 32'h5);
    fetch("R3 as address", 30'h20, 32'h80, 0, 0);
    check("R3 literal", 32'(bp_hits), 32'h08);
    // R1 out-of-range writes
    wr(0, 3'd6, 32'h0); wr(1, 3'd7, 32'h1);
    fetch("R1 no alias", 30'h20, 32'h80, 0, 0);
    // R10 random mix
    for (int n = 0; n < 4000; n++) begin
      logic we = ($urandom % 3) == 0;
      logic wc = $urandom % 2;
      step("R10 random", we, wc, 3'($urandom % 8),
           wc ? 32'($urandom % 128) : 32'($urandom % 16),
           ($urandom % 4) != 0, 30'($urandom % 4), 32'($urandom % 16),
           $urandom % 2, $urandom % 2);
    end
    finish_run();
  end

endmodule